// File: doc/BRIEF.md
# Complement-Protected Serial Configuration Register File

This block is a write-only serial slave that holds the configuration of a low-speed FSK modem: a general control byte, a clock-divider byte, an analog-enable byte and a 17-bit sigma-delta DAC code. A host sends a frame while chip select is held high. Each frame starts with one command byte that carries the register address and continues with data bytes. The serial lines are resynchronised into the system clock domain, and every bit is taken on a falling edge of the serial clock (mode 1), most significant bit first.

Each 8-bit register is protected against stray writes. The host sends the bitwise inverse of the value first and then the value itself. The register takes the value only if the two bytes agree, the address is known and the byte count is exact. The DAC code arrives as three bytes, and a one-cycle strobe marks every accepted DAC update so that it can serve as a watchdog kick. Nothing is committed until chip select falls.

The controller is a state machine with five states. `ST_IDLE` waits for chip select. `ST_CMD` shifts in the address byte. `ST_PAYLOAD` shifts in and counts data bytes. `ST_OVER` absorbs a frame that has too many bytes. `ST_COMMIT` lasts one cycle and decides the write. The transitions are:
- idle→cmd when chip select is high.
- cmd→payload when eight bits are complete.
- cmd→idle when chip select drops before the command byte is done.
- payload→over when a fourth data byte completes.
- payload→commit when chip select drops.
- over→idle when chip select drops.
- commit→idle always.

Top module: `cfg_spi_regfile`

## Requirements
- R1: After reset, and whenever reset is applied again, the registers hold their default values. The general byte is 0x85: receive idle level 0, clock monitor disabled 1, kick source 01. The clock byte is 0xB7. The analog byte is 0xFD. The DAC code is 0. The update strobe is low.
- R2: A frame of address 0x01, then the inverse byte, then a data byte D updates the general register to D. Its fields are: receive idle level = D[4], clock monitor disable = D[2], kick source = D[1:0] (00 off, 01 external pin, 10 DAC write).
- R3: A complement-checked frame to address 0x02 loads the clock byte D. The second clock output divider code is D[7:5], the first clock output divider code is D[4:2], and the system divider code is D[1:0].
- R4: A complement-checked frame to address 0x03 loads all eight analog disable bits from D[7:0].
- R5: If the first data byte is not the bitwise inverse of the second, the frame leaves every register unchanged.
- R6: A frame with the wrong number of data bytes for its address (fewer, more, or more than three) leaves every register unchanged. So does a frame that ends in the middle of a byte. Neither kind produces an update strobe.
- R7: A frame to any address other than 0x01, 0x02, 0x03 or 0x0A changes no register.
- R8: A frame to address 0x0A with exactly three data bytes loads the DAC code from bits 23:7 of the 24-bit payload. Payload bits 6:0 are ignored.
- R9: Every accepted DAC write raises the update strobe for exactly one system clock. No other frame raises it.
- R10: A write takes effect only after chip select falls. While chip select stays high after the last byte, the registers keep their old values.
- R11: Serial clock edges while chip select is low are ignored. They change no register, and they do not disturb the framing of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low, data taken on its falling edge |
| spi_mosi | input | 1 | Serial data, MSB first |
| spi_csel | input | 1 | Chip select, high during a frame |
| rxd_idle_high | output | 1 | Receive data idle level field |
| clkmon_off | output | 1 | Clock monitor disable field |
| kick_src | output | 2 | Watchdog kick source field |
| clkout2_div | output | 3 | Divider code for the second clock output |
| clkout1_div | output | 3 | Divider code for the first clock output |
| sysclk_div | output | 2 | System clock divider code |
| analog_off | output | 8 | Analog block disable bits |
| sd_value | output | 17 | Sigma-delta DAC code |
| sd_update | output | 1 | One-cycle strobe on an accepted DAC write |

## Verification
Several properties are checked on every cycle:
- The update strobe never lasts more than one cycle.
- The DAC code never moves without the strobe.
- No 8-bit register changes unless its write strobe was raised the cycle before.
- At most one register write strobe fires in any cycle.
- The commit state is reached only from the payload state, and an overlong frame never reaches it.

Whether a given frame should be accepted can only be shown by the bench's scenarios. These cover the inverse-byte check, short, long and partial frames, unknown addresses, the bit slice that feeds the DAC, holding chip select high after the data, and stray clocks between frames.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int SD_W      = 17;
    localparam int PAY_BYTES = 3;
    localparam int PAY_W     = PAY_BYTES * BYTE_W;
    localparam int CNT_W     = 2;
    localparam int CFG_BYTES = 2;
    localparam int NUM_CFG   = 3;

    localparam logic [BYTE_W-1:0] ADDR_GEN = 8'h01;
    localparam logic [BYTE_W-1:0] ADDR_CLK = 8'h02;
    localparam logic [BYTE_W-1:0] ADDR_ANA = 8'h03;
    localparam logic [BYTE_W-1:0] ADDR_SD  = 8'h0A;

    localparam logic [BYTE_W-1:0] RST_GEN = 8'h85;
    localparam logic [BYTE_W-1:0] RST_CLK = 8'hB7;
    localparam logic [BYTE_W-1:0] RST_ANA = 8'hFD;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_PAYLOAD,
        ST_OVER,
        ST_COMMIT
    } frame_state_t;
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic mosi_i,
    input  logic csel_i,
    output logic sclk_fall_o,
    output logic mosi_o,
    output logic csel_o
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sclk_last;

    assign raw = {csel_i, mosi_i, sclk_i};

    for (genvar g = 0; g < NSIG; g++) begin : g_chain
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_last <= 1'b0;
        else        sclk_last <= synced[0];
    end

    assign sclk_fall_o = sclk_last & ~synced[0];
    assign mosi_o      = synced[1];
    assign csel_o      = synced[2];
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import cfg_spi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_fall,
    input  logic                mosi,
    input  logic                csel,
    output logic                wr_gen,
    output logic                wr_clk,
    output logic                wr_ana,
    output logic                wr_sd,
    output logic [BYTE_W-1:0]   cfg_byte,
    output logic [SD_W-1:0]     sd_word
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT   = BIT_CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0]     CNT_CFG    = CNT_W'(CFG_BYTES);
    localparam logic [CNT_W-1:0]     CNT_SD     = CNT_W'(PAY_BYTES);

    frame_state_t           state, nxt;
    logic [BIT_CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-2:0]      shreg;
    logic [BYTE_W-1:0]      cmd_q;
    logic [PAY_W-1:0]       pay_q;
    logic [CNT_W-1:0]       byte_cnt;
    logic                   byte_done;
    logic [BYTE_W-1:0]      byte_in;
    logic                   clean;
    logic                   cfg_ok;
    logic                   commit;

    assign byte_done = sclk_fall && (bit_cnt == LAST_BIT);
    assign byte_in   = {shreg, mosi};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (csel) nxt = ST_CMD;
            ST_CMD: begin
                if (!csel)          nxt = ST_IDLE;
                else if (byte_done) nxt = ST_PAYLOAD;
            end
            ST_PAYLOAD: begin
                if (!csel)                               nxt = ST_COMMIT;
                else if (byte_done && byte_cnt == CNT_SD) nxt = ST_OVER;
            end
            ST_OVER:    if (!csel) nxt = ST_IDLE;
            ST_COMMIT:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // datapath: bit and byte collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            cmd_q    <= '0;
            pay_q    <= '0;
            byte_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (csel) begin
                    bit_cnt  <= '0;
                    byte_cnt <= '0;
                    pay_q    <= '0;
                end
                ST_CMD, ST_PAYLOAD: if (csel && sclk_fall) begin
                    shreg   <= byte_in[BYTE_W-2:0];
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        if (state == ST_CMD) begin
                            cmd_q <= byte_in;
                        end else begin
                            pay_q    <= {pay_q[PAY_W-BYTE_W-1:0], byte_in};
                            byte_cnt <= byte_cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        commit   = (state == ST_COMMIT);
        clean    = (bit_cnt == '0);
        cfg_ok   = (byte_cnt == CNT_CFG) &&
                   (pay_q[2*BYTE_W-1:BYTE_W] == ~pay_q[BYTE_W-1:0]);
        wr_gen   = commit && clean && cfg_ok && (cmd_q == ADDR_GEN);
        wr_clk   = commit && clean && cfg_ok && (cmd_q == ADDR_CLK);
        wr_ana   = commit && clean && cfg_ok && (cmd_q == ADDR_ANA);
        wr_sd    = commit && clean && (byte_cnt == CNT_SD) && (cmd_q == ADDR_SD);
        cfg_byte = pay_q[BYTE_W-1:0];
        sd_word  = pay_q[PAY_W-1:PAY_W-SD_W];
    end

    a_r10_commit_after_payload: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_COMMIT |-> $past(state) == ST_PAYLOAD);
    a_r6_over_never_commits: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_OVER |=> state != ST_COMMIT);
    a_r7_single_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_gen, wr_clk, wr_ana, wr_sd}));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_spi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_gen,
    input  logic                wr_clk,
    input  logic                wr_ana,
    input  logic                wr_sd,
    input  logic [BYTE_W-1:0]   cfg_byte,
    input  logic [SD_W-1:0]     sd_word,
    output logic [BYTE_W-1:0]   gen_q,
    output logic [BYTE_W-1:0]   clk_q,
    output logic [BYTE_W-1:0]   ana_q,
    output logic [SD_W-1:0]     sd_q,
    output logic                sd_pulse
);
    localparam logic [NUM_CFG-1:0][BYTE_W-1:0] RST_VALS = {RST_ANA, RST_CLK, RST_GEN};

    logic [NUM_CFG-1:0]             wr_vec;
    logic [NUM_CFG-1:0][BYTE_W-1:0] regs;

    assign wr_vec = {wr_ana, wr_clk, wr_gen};

    for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        regs[i] <= RST_VALS[i];
            else if (wr_vec[i]) regs[i] <= cfg_byte;
        end

        a_r5_cfg_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(wr_vec[i]) |-> $stable(regs[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_q     <= '0;
            sd_pulse <= 1'b0;
        end else begin
            sd_pulse <= wr_sd;
            if (wr_sd) sd_q <= sd_word;
        end
    end

    assign gen_q = regs[0];
    assign clk_q = regs[1];
    assign ana_q = regs[2];
endmodule

// File: rtl/cfg_spi_regfile.sv
module cfg_spi_regfile
    import cfg_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spi_sclk,
    input  logic            spi_mosi,
    input  logic            spi_csel,
    output logic            rxd_idle_high,
    output logic            clkmon_off,
    output logic [1:0]      kick_src,
    output logic [2:0]      clkout2_div,
    output logic [2:0]      clkout1_div,
    output logic [1:0]      sysclk_div,
    output logic [7:0]      analog_off,
    output logic [16:0]     sd_value,
    output logic            sd_update
);
    logic                sclk_fall, mosi_s, csel_s;
    logic                wr_gen, wr_clk, wr_ana, wr_sd;
    logic [BYTE_W-1:0]   cfg_byte;
    logic [SD_W-1:0]     sd_word;
    logic [BYTE_W-1:0]   gen_q, clk_q, ana_q;

    spi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (spi_sclk),
        .mosi_i      (spi_mosi),
        .csel_i      (spi_csel),
        .sclk_fall_o (sclk_fall),
        .mosi_o      (mosi_s),
        .csel_o      (csel_s)
    );

    spi_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_fall (sclk_fall),
        .mosi      (mosi_s),
        .csel      (csel_s),
        .wr_gen    (wr_gen),
        .wr_clk    (wr_clk),
        .wr_ana    (wr_ana),
        .wr_sd     (wr_sd),
        .cfg_byte  (cfg_byte),
        .sd_word   (sd_word)
    );

    cfg_reg_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_gen   (wr_gen),
        .wr_clk   (wr_clk),
        .wr_ana   (wr_ana),
        .wr_sd    (wr_sd),
        .cfg_byte (cfg_byte),
        .sd_word  (sd_word),
        .gen_q    (gen_q),
        .clk_q    (clk_q),
        .ana_q    (ana_q),
        .sd_q     (sd_value),
        .sd_pulse (sd_update)
    );

    // field decode; positions are fixed by the host software
    assign rxd_idle_high = gen_q[4];
    assign clkmon_off    = gen_q[2];
    assign kick_src      = gen_q[1:0];
    assign clkout2_div   = clk_q[7:5];
    assign clkout1_div   = clk_q[4:2];
    assign sysclk_div    = clk_q[1:0];
    assign analog_off    = ana_q;

    a_r9_strobe_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sd_update |=> !sd_update);
    a_r8_dac_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_update |-> $stable(sd_value));
endmodule

// File: tb/cfg_spi_regfile_test.sv
module cfg_spi_regfile_test;
    localparam int HALF = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, mosi = 1'b0, csel = 1'b0;
    logic        rxd_idle_high, clkmon_off, sd_update;
    logic [1:0]  kick_src, sysclk_div;
    logic [2:0]  clkout2_div, clkout1_div;
    logic [7:0]  analog_off;
    logic [16:0] sd_value;

    int n_chk = 0, n_fail = 0, pulses = 0;

    always #4 clk = ~clk;

    cfg_spi_regfile uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_csel(csel),
        .rxd_idle_high(rxd_idle_high), .clkmon_off(clkmon_off), .kick_src(kick_src),
        .clkout2_div(clkout2_div), .clkout1_div(clkout1_div), .sysclk_div(sysclk_div),
        .analog_off(analog_off), .sd_value(sd_value), .sd_update(sd_update)
    );

    always @(posedge clk) if (rst_n && sd_update) pulses++;

    typedef struct packed {
        logic [2:0]  nb;
        logic [39:0] frm;
        logic [7:0]  eg;
        logic [7:0]  ec;
        logic [7:0]  ea;
        logic [16:0] esd;
        logic [1:0]  epl;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd3, 40'h01ED120000, 8'h12, 8'hB7, 8'hFD, 17'h00000, 2'd0, 4'd2},  // R2 general write
        '{3'd3, 40'h02D6290000, 8'h12, 8'h29, 8'hFD, 17'h00000, 2'd0, 4'd3},  // R3 clock fields
        '{3'd3, 40'h03A55A0000, 8'h12, 8'h29, 8'h5A, 17'h00000, 2'd0, 4'd4},  // R4 analog byte
        '{3'd3, 40'h0100330000, 8'h12, 8'h29, 8'h5A, 17'h00000, 2'd0, 4'd5},  // R5 bad inverse
        '{3'd2, 40'h01ED000000, 8'h12, 8'h29, 8'h5A, 17'h00000, 2'd0, 4'd6},  // R6 too short
        '{3'd4, 40'h01CC330000, 8'h12, 8'h29, 8'h5A, 17'h00000, 2'd0, 4'd6},  // R6 too long
        '{3'd3, 40'h04CC330000, 8'h12, 8'h29, 8'h5A, 17'h00000, 2'd0, 4'd7},  // R7 unknown address
        '{3'd4, 40'h0AABCDEF00, 8'h12, 8'h29, 8'h5A, 17'h1579B, 2'd1, 4'd8},  // R8 + R9 strobe
        '{3'd3, 40'h0A11220000, 8'h12, 8'h29, 8'h5A, 17'h1579B, 2'd0, 4'd6},  // R6 short DAC, R9 no strobe
        '{3'd4, 40'h0AFFFF8000, 8'h12, 8'h29, 8'h5A, 17'h1FFFF, 2'd1, 4'd8},  // R8 full scale
        '{3'd4, 40'h0A00007F00, 8'h12, 8'h29, 8'h5A, 17'h00000, 2'd1, 4'd8},  // R8 low bits ignored
        '{3'd3, 40'h01FE010000, 8'h01, 8'h29, 8'h5A, 17'h00000, 2'd0, 4'd2},  // R2 kick from pin
        '{3'd3, 40'h0229290000, 8'h01, 8'h29, 8'h5A, 17'h00000, 2'd0, 4'd5},  // R5 clock bad inverse
        '{3'd5, 40'h0A11223344, 8'h01, 8'h29, 8'h5A, 17'h00000, 2'd0, 4'd6}   // R6 overlong DAC
    };

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic chk_regs(input string rq, input logic [7:0] eg, input logic [7:0] ec,
                            input logic [7:0] ea, input logic [16:0] esd);
        chk(rq, "general fields", {28'd0, rxd_idle_high, clkmon_off, kick_src},
            {28'd0, eg[4], eg[2], eg[1:0]});
        chk(rq, "clock fields", {24'd0, clkout2_div, clkout1_div, sysclk_div}, {24'd0, ec});
        chk(rq, "analog bits", {24'd0, analog_off}, {24'd0, ea});
        chk(rq, "dac code", {15'd0, sd_value}, {15'd0, esd});
    endtask

    task automatic send_frame(input int nb, input logic [39:0] frm, input int extra, input bit hold);
        @(negedge clk) csel = 1'b1;
        repeat (4) @(negedge clk);
        for (int b = 0; b < nb * 8 + extra; b++) begin
            mosi = (b < 40) ? frm[39 - b] : 1'b0;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        if (!hold) begin
            csel = 1'b0;
            repeat (12) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int p0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk_regs("R1", 8'h85, 8'hB7, 8'hFD, 17'h0);
        chk("R1", "strobe idle", {31'd0, sd_update}, 32'd0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            p0 = pulses;
            send_frame(int'(VECS[v].nb), VECS[v].frm, 0, 1'b0);
            chk($sformatf("R%0d", VECS[v].rq), $sformatf("vector %0d", v), 32'd0, 32'd0);
            chk_regs($sformatf("R%0d", VECS[v].rq), VECS[v].eg, VECS[v].ec, VECS[v].ea, VECS[v].esd);
            chk("R9", "strobe count", pulses - p0, {30'd0, VECS[v].epl});
        end

        // R10: chip select held high after the last byte
        p0 = pulses;
        send_frame(4, 40'h0A12345600, 0, 1'b1);
        repeat (20) @(negedge clk);
        chk("R10", "dac before cs fall", {15'd0, sd_value}, 32'd0);
        chk("R10", "no early strobe", pulses - p0, 32'd0);
        csel = 1'b0;
        repeat (12) @(negedge clk);
        chk("R10", "dac after cs fall", {15'd0, sd_value}, 32'h2468);
        chk("R9", "strobe after cs fall", pulses - p0, 32'd1);

        // R11: clocks with chip select low
        for (int k = 0; k < 16; k++) begin
            mosi = k[0];
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        chk_regs("R11", 8'h01, 8'h29, 8'h5A, 17'h2468);
        send_frame(3, 40'h01EB140000, 0, 1'b0);
        chk_regs("R11", 8'h14, 8'h29, 8'h5A, 17'h2468);

        // R6: frame ending mid-byte
        send_frame(3, 40'h01FE010000, 3, 1'b0);
        chk_regs("R6", 8'h14, 8'h29, 8'h5A, 17'h2468);

        // R1: reset applied again
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_regs("R1", 8'h85, 8'hB7, 8'hFD, 17'h0);

        finish_run();
    end
endmodule